// File: doc/BRIEF.md
# Production-Test Clock Divider Bank

This block makes every output clock of a clock generator from one reference while the chip is in production test mode. Its only clock is a fast clock that runs at twice the reference rate. It produces two kinds of output. The divided groups are register-driven levels: a reference copy, a second reference copy for the interrupt controller, a half-rate output, a quarter-rate output and a bank of bus clocks. The CPU and SDRAM groups run at twice the reference rate, which is the fast clock itself. For those groups the block drives gate enables, and the clock tree ANDs each enable with the fast clock.

The three select straps and the bus-mode strap are captured while reset is held. After reset they are frozen. Test mode applies only when the captured select code is 110. In any other code every output stays low, so the normal synthesis path can own the pins. All dividers start together at the first edge after reset. All divided outputs therefore rise on that same edge, and their rising edges stay aligned at every common multiple of their periods. The block has no streaming data path, so every pin is a plain control or clock level.

Top module: `tclk_test_divbank`

## Requirements
- R1: The straps `strap_sel` and `strap_bus` are sampled on every clock edge while `rst_n` is low. The last sampled values hold until the next reset. Strap changes while `rst_n` is high have no effect on any output.
- R2: Test mode is active only when the captured `strap_sel` equals 3'b110 (bit 2 = 1, bit 1 = 1, bit 0 = 0).
- R3: When test mode is not active, every output, including all gate enables, is 0.
- R4: In test mode, `ref_o` and `ioapic_o` toggle on every fast-clock edge (period 2 fast cycles, 1 high / 1 low). Their first value after reset is 1.
- R5: In test mode, `usb_o` has a period of 4 fast cycles (reference/2), 2 high followed by 2 low.
- R6: In test mode, `fix24_o` has a period of 8 fast cycles (reference/4), 4 high followed by 4 low.
- R7: In test mode, every bit of `bus_o` has the same waveform. With captured `strap_bus` = 1 the period is 8 fast cycles (4 high, 4 low). With `strap_bus` = 0 the period is 6 fast cycles (3 high, 3 low), which is reference/3 at exactly 50% duty.
- R8: In test mode, every bit of `cpu_gate_o` and `sdram_gate_o` is 1 from the first edge after reset onward. The gated outputs therefore pulse on every fast edge, which is twice the reference rate.
- R9: In test mode, all divided outputs become 1 on the first clock edge after `rst_n` rises. Counting that edge as edge 1, an output with period P fast cycles is 1 after edge k exactly when (k-1) mod P < P/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the reference rate |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_sel | input | 3 | Frequency-select straps |
| strap_bus | input | 1 | Bus-mode strap (1: reference/4, 0: reference/3) |
| ref_o | output | 1 | Reference-rate copy |
| ioapic_o | output | 1 | Second reference-rate copy |
| usb_o | output | 1 | Reference/2 output |
| fix24_o | output | 1 | Reference/4 output |
| bus_o | output | N_BUS (6) | Bus clock bank |
| cpu_gate_o | output | N_CPU (3) | Gate enables for the CPU outputs (×2 reference) |
| sdram_gate_o | output | N_SDRAM (12) | Gate enables for the SDRAM outputs (×2 reference) |

## Verification
The bench checks the phase of every divided output against the edge count from reset release. It does this cycle by cycle for both bus modes. A divider that started one cycle late, or that reset its counter on its own, would show a rising edge that is out of line with the other outputs. The divide-by-3 bus mode is checked for an exact 3-high, 3-low pattern, because an off-by-one terminal count gives a 2/4 or 4/2 duty or a 5- or 7-cycle period. Strap codes next to 110 are driven to confirm that they keep every output and gate low; a loose decode would switch test mode on for them. Straps are also changed after reset, and the waveforms must not change, which catches a latch that stays transparent.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

  localparam logic [2:0] TEST_SEL_CODE = 3'b110;

  typedef struct packed {
    logic [2:0] sel;
    logic       bus_mode;
  } strap_t;

  function automatic logic is_test_code(input strap_t s);
    return (s.sel == TEST_SEL_CODE);
  endfunction

endpackage

// File: rtl/tclk_strap_latch.sv
module tclk_strap_latch
  import tclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_pins,
  input  logic       bus_pin,
  output logic       test_active,
  output logic       bus_div3
);

  strap_t held_q;

  // Transparent during reset, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q.sel      <= sel_pins;
      held_q.bus_mode <= bus_pin;
    end
  end

  assign test_active = is_test_code(held_q);
  assign bus_div3    = ~held_q.bus_mode;

endmodule

// File: rtl/tclk_phase_div.sv
module tclk_phase_div #(
  parameter int MAX_HALF = 4,
  localparam int MAX_PER = 2 * MAX_HALF,
  localparam int CW      = (MAX_PER > 1) ? $clog2(MAX_PER) : 1,
  localparam int HW      = $clog2(MAX_HALF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half_len,
  output logic          wave
);

  logic [CW-1:0] phase_q;
  logic [CW:0]   period;
  logic          wrap;

  assign period = {half_len, 1'b0};
  assign wrap   = ({1'b0, phase_q} == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
      wave    <= 1'b0;
    end else begin
      wave    <= ({1'b0, phase_q} < {{(CW+1-HW){1'b0}}, half_len});
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tclk_test_divbank.sv
module tclk_test_divbank #(
  parameter int N_BUS   = 6,
  parameter int N_CPU   = 3,
  parameter int N_SDRAM = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         strap_sel,
  input  logic               strap_bus,
  output logic               ref_o,
  output logic               ioapic_o,
  output logic               usb_o,
  output logic               fix24_o,
  output logic [N_BUS-1:0]   bus_o,
  output logic [N_CPU-1:0]   cpu_gate_o,
  output logic [N_SDRAM-1:0] sdram_gate_o
);

  // Half periods measured in fast-clock cycles.
  localparam int REF_HALF  = 1;
  localparam int USB_HALF  = 2;
  localparam int F24_HALF  = 4;
  localparam int BUS4_HALF = 4;
  localparam int BUS3_HALF = 3;
  localparam int BUS_MAXH  = (BUS4_HALF > BUS3_HALF) ? BUS4_HALF : BUS3_HALF;
  localparam int BHW       = $clog2(BUS_MAXH + 1);

  logic mode_on;
  logic bus_div3;
  logic ref_w, usb_w, f24_w, bus_w;
  logic [BHW-1:0] bus_half;
  logic gate_q;

  tclk_strap_latch u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_pins   (strap_sel),
    .bus_pin    (strap_bus),
    .test_active(mode_on),
    .bus_div3   (bus_div3)
  );

  tclk_phase_div #(.MAX_HALF(REF_HALF)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(mode_on),
    .half_len(1'(REF_HALF)), .wave(ref_w)
  );

  tclk_phase_div #(.MAX_HALF(USB_HALF)) u_usb (
    .clk(clk), .rst_n(rst_n), .run(mode_on),
    .half_len(2'(USB_HALF)), .wave(usb_w)
  );

  tclk_phase_div #(.MAX_HALF(F24_HALF)) u_f24 (
    .clk(clk), .rst_n(rst_n), .run(mode_on),
    .half_len(3'(F24_HALF)), .wave(f24_w)
  );

  assign bus_half = bus_div3 ? BHW'(BUS3_HALF) : BHW'(BUS4_HALF);

  tclk_phase_div #(.MAX_HALF(BUS_MAXH)) u_bus (
    .clk(clk), .rst_n(rst_n), .run(mode_on),
    .half_len(bus_half), .wave(bus_w)
  );

  // Gate enables are registered so they start on the same edge as the dividers.
  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= mode_on;
  end

  assign ref_o    = ref_w;
  assign ioapic_o = ref_w;
  assign usb_o    = usb_w;
  assign fix24_o  = f24_w;

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    assign bus_o[b] = bus_w;
  end
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign cpu_gate_o[c] = gate_q;
  end
  for (genvar s = 0; s < N_SDRAM; s++) begin : g_sdram
    assign sdram_gate_o[s] = gate_q;
  end

endmodule

// File: rtl/tclk_test_divbank_chk.sv
module tclk_test_divbank_chk #(
  parameter int N_BUS   = 6,
  parameter int N_CPU   = 3,
  parameter int N_SDRAM = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_on,
  input logic               bus_div3,
  input logic               ref_o,
  input logic               ioapic_o,
  input logic               usb_o,
  input logic               fix24_o,
  input logic [N_BUS-1:0]   bus_o,
  input logic [N_CPU-1:0]   cpu_gate_o,
  input logic [N_SDRAM-1:0] sdram_gate_o
);

  p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_on));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |-> (!ref_o && !ioapic_o && !usb_o && !fix24_o &&
                  bus_o == '0 && cpu_gate_o == '0 && sdram_gate_o == '0));

  p_ref_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on |=> (ref_o != $past(ref_o)));

  p_usb_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && $rose(usb_o)) |=> usb_o);

  p_edge_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix24_o) |-> (usb_o && ref_o && ioapic_o));

  p_bus_third_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && bus_div3 && $fell(bus_o[0])) |->
      ($past(bus_o[0], 3) && !$past(bus_o[0], 4)));

  p_bus_quarter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !bus_div3 && $fell(bus_o[0])) |->
      ($past(bus_o[0], 4) && !$past(bus_o[0], 5)));

  p_gates_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on |=> ((&cpu_gate_o) && (&sdram_gate_o)));

endmodule

bind tclk_test_divbank tclk_test_divbank_chk #(
  .N_BUS(N_BUS), .N_CPU(N_CPU), .N_SDRAM(N_SDRAM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .bus_div3(bus_div3),
  .ref_o(ref_o), .ioapic_o(ioapic_o), .usb_o(usb_o), .fix24_o(fix24_o),
  .bus_o(bus_o), .cpu_gate_o(cpu_gate_o), .sdram_gate_o(sdram_gate_o)
);

// File: tb/tb_tclk_test_divbank.sv
module tb_tclk_test_divbank;

  localparam int N_BUS = 6, N_CPU = 3, N_SDRAM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap_sel = 3'b000;
  logic strap_bus = 1'b0;
  logic ref_o, ioapic_o, usb_o, fix24_o;
  logic [N_BUS-1:0] bus_o;
  logic [N_CPU-1:0] cpu_gate_o;
  logic [N_SDRAM-1:0] sdram_gate_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tclk_test_divbank #(.N_BUS(N_BUS), .N_CPU(N_CPU), .N_SDRAM(N_SDRAM)) dut (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .strap_bus(strap_bus),
    .ref_o(ref_o), .ioapic_o(ioapic_o), .usb_o(usb_o), .fix24_o(fix24_o),
    .bus_o(bus_o), .cpu_gate_o(cpu_gate_o), .sdram_gate_o(sdram_gate_o)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit wave_at(input int k, input int half);
    return ((k - 1) % (2 * half)) < half;
  endfunction

  task automatic apply_reset(input logic [2:0] sel, input logic bmode);
    @(negedge clk);
    rst_n = 1'b0;
    strap_sel = sel;
    strap_bus = bmode;
    repeat (4) @(negedge clk);
    // reset state
    check("R3", "reset ref", ref_o, 0);
    check("R3", "reset gates", {cpu_gate_o, sdram_gate_o}, 0);
    rst_n = 1'b1;
  endtask

  // Test mode: check every divided output against the edge count (R4-R9).
  task automatic run_test_mode(input logic bmode, input bit wiggle);
    int bh;
    bh = bmode ? 4 : 3;
    apply_reset(3'b110, bmode);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (wiggle && k == 5) begin
        strap_sel = 3'b000;   // R1: post-reset strap changes must not matter
        strap_bus = ~bmode;
      end
      check(wiggle ? "R1" : "R4", "ref", ref_o, wave_at(k, 1));
      check("R4", "ioapic", ioapic_o, wave_at(k, 1));
      check("R5", "usb", usb_o, wave_at(k, 2));
      check("R6", "fix24", fix24_o, wave_at(k, 4));
      check("R7", "bus", bus_o, wave_at(k, bh) ? {N_BUS{1'b1}} : '0);
      check("R8", "gates", {cpu_gate_o, sdram_gate_o}, {(N_CPU + N_SDRAM){1'b1}});
      if (k == 1)
        check("R9", "aligned start", {ref_o, usb_o, fix24_o, bus_o[0]}, 4'b1111);
    end
  endtask

  // Non-test codes: everything must stay low (R2, R3).
  task automatic run_idle(input logic [2:0] sel, input logic bmode);
    apply_reset(sel, bmode);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 3) strap_sel = 3'b110;  // R1: late test code is ignored
      check("R2", "idle divided", {ref_o, ioapic_o, usb_o, fix24_o, bus_o}, 0);
      check("R3", "idle gates", {cpu_gate_o, sdram_gate_o}, 0);
    end
  endtask

  initial begin
    run_test_mode(1'b1, 1'b0);
    run_test_mode(1'b0, 1'b0);
    run_test_mode(1'b0, 1'b1);
    run_test_mode(1'b1, 1'b1);
    run_idle(3'b111, 1'b1);
    run_idle(3'b100, 1'b0);
    run_idle(3'b010, 1'b1);
    run_idle(3'b000, 1'b0);
    run_idle(3'b011, 1'b1);
    run_test_mode(1'b0, 1'b0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule